// File: doc/BRIEF.md
# Decryption Access Guard

This block sits next to a memory-mapped decryption path and judges every bus access as it happens. It compares the access address with up to four configurable address windows. It then decides, in the same cycle, whether the data path may return the decrypted word or must return zeros. The decision depends on the window's 2-bit mode, whether the access is a data read, an instruction fetch or a write, the window's key checksum, and a global encrypt-mode input.

Three sticky error flags record the refused accesses: security error, execute-only/execute-never violation, and bad key. Each flag has an enable bit, and each is cleared by writing one to a clear register. A single interrupt line is raised when any enabled flag is set. Software reaches the flags through a small register port with a 2-bit word select. The cipher itself is not part of this block.

Top module: `agd_access_guard`

## Requirements
- R1: A window matches when its enable input is 1 and start <= address <= end, with both bounds inclusive. When several windows match, the one with the lowest index is used, and its mode and checksum decide the access.
- R2: A data read (write = 0, fetch = 0) that matches a window whose mode is 2'b11 drives `force_zero_o` high in the same cycle and sets flag bit 1.
- R3: An instruction fetch (fetch = 1, write = 0) while `enc_mode_i` is 1 drives `force_zero_o` high and sets flag bit 1, whether or not it matches a window. A fetch to a mode-2'b11 window while `enc_mode_i` is 0 is let through and sets no flag.
- R4: A read or fetch that matches a window whose 8-bit key checksum is 8'h00 drives `force_zero_o` high and sets flag bit 2.
- R5: A window with a zero checksum keeps returning zeros after flag bit 2 has been cleared. Reads pass again once its checksum is nonzero.
- R6: A write access never raises `force_zero_o` and sets no flag.
- R7: A one-cycle pulse on `sec_err_i` sets flag bit 0.
- R8: Flags are sticky. Writing 1s to the clear register (select 1) clears the matching bits. Writes to the status register (select 0) have no effect. Reading select 1 returns 0.
- R9: The enable register (select 2, bits [2:0]) is read/write, and its value reads back unchanged.
- R10: `irq_o` goes high one clock after (flags AND enables) becomes nonzero, and goes low one clock after that term becomes zero.
- R11: A flag that is set by hardware and cleared by software in the same cycle stays set.
- R12: After reset, all flags, enables and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is present this cycle |
| acc_addr_i | input | ADDR_W | Access address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| enc_mode_i | input | 1 | Global encrypt mode |
| sec_err_i | input | 1 | Security error pulse |
| rgn_en_i | input | NUM_RGN | Per-window enable |
| rgn_start_i | input | NUM_RGN*ADDR_W | Per-window start address, window i at slice i |
| rgn_end_i | input | NUM_RGN*ADDR_W | Per-window end address (inclusive) |
| rgn_mode_i | input | NUM_RGN*2 | Per-window mode, 2'b11 = execute only |
| rgn_crc_i | input | NUM_RGN*CRC_W | Per-window key checksum, 0 = key invalid |
| reg_sel_i | input | 2 | Register word select: 0 status, 1 clear, 2 enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 3 | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from select |
| force_zero_o | output | 1 | Return zeros for this access |
| irq_o | output | 1 | Registered interrupt |

## Verification
A wrong window choice or a wrong mode or checksum decode shows up on `force_zero_o` in the same cycle as the access. The register port shows it too, in the flag bits read right after the next clock edge. A stuck or lost flag shows up in the next status read. A wrong enable or interrupt state shows up on `irq_o` no more than one clock after the flag/enable combination changes. Overlapping windows, exact boundary addresses and a set and clear landing together are each placed so that the wrong outcome differs at the ports.

// File: rtl/agd_pkg.sv
package agd_pkg;

    localparam int NUM_FLAGS = 3;

    // Flag bit positions, shared by status, clear and enable registers
    localparam int FLAG_SEC = 0;
    localparam int FLAG_XO  = 1;
    localparam int FLAG_KEY = 2;

    // Register word selects
    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_CLR  = 2'd1;
    localparam logic [1:0] SEL_EN   = 2'd2;

    // Window mode that forbids plain data reads
    localparam logic [1:0] MODE_XO = 2'b11;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
        flag_vec_t en;
        logic      irq;
    } flag_state_t;

endpackage

// File: rtl/agd_region_match.sv
module agd_region_match #(
    parameter int NUM_RGN = 4,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 2
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [NUM_RGN-1:0]        en_i,
    input  logic [NUM_RGN*ADDR_W-1:0] start_i,
    input  logic [NUM_RGN*ADDR_W-1:0] end_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [NUM_RGN-1:0]        sel_o
);

    logic [NUM_RGN-1:0] in_rng;

    // One comparator pair per window
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        assign lo = start_i[g*ADDR_W +: ADDR_W];
        assign hi = end_i[g*ADDR_W +: ADDR_W];
        assign in_rng[g] = en_i[g] && (addr_i >= lo) && (addr_i <= hi);
    end

    // Lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_RGN - 1; i >= 0; i--) begin
            if (in_rng[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // Isolated lowest set bit, a separate path used by the checks
    assign sel_o = in_rng & ~(in_rng - NUM_RGN'(1));

endmodule

// File: rtl/agd_access_judge.sv
module agd_access_judge #(
    parameter int CRC_W = 8
) (
    input  logic             valid_i,
    input  logic             write_i,
    input  logic             fetch_i,
    input  logic             enc_mode_i,
    input  logic             hit_i,
    input  logic [1:0]       mode_i,
    input  logic [CRC_W-1:0] crc_i,
    output logic             force_zero_o,
    output logic             xo_set_o,
    output logic             key_set_o
);
    import agd_pkg::*;

    logic rd;
    logic fetch_in_enc;
    logic data_in_xo;
    logic key_bad;

    always_comb begin
        rd           = valid_i && !write_i;
        fetch_in_enc = rd && fetch_i && enc_mode_i;
        data_in_xo   = rd && !fetch_i && hit_i && (mode_i == MODE_XO);
        key_bad      = rd && hit_i && (crc_i == '0);

        xo_set_o     = fetch_in_enc || data_in_xo;
        key_set_o    = key_bad;
        force_zero_o = fetch_in_enc || data_in_xo || key_bad;
    end

endmodule

// File: rtl/agd_flag_regs.sv
module agd_flag_regs #(
    parameter int DATA_W = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  agd_pkg::flag_vec_t       set_i,
    input  logic [1:0]               reg_sel_i,
    input  logic                     reg_wr_i,
    input  agd_pkg::flag_vec_t       reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    output logic                     irq_o
);
    import agd_pkg::*;

    flag_state_t st_d;
    flag_state_t st_q;
    flag_vec_t   clr_mask;

    always_comb begin
        clr_mask = (reg_wr_i && reg_sel_i == SEL_CLR) ? reg_wdata_i : '0;

        st_d       = st_q;
        // hardware set takes precedence over a same-cycle clear
        st_d.flags = (st_q.flags & ~clr_mask) | set_i;
        if (reg_wr_i && reg_sel_i == SEL_EN) begin
            st_d.en = reg_wdata_i;
        end
        st_d.irq   = |(st_q.flags & st_q.en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel_i)
            SEL_STAT: reg_rdata_o = DATA_W'(st_q.flags);
            SEL_EN:   reg_rdata_o = DATA_W'(st_q.en);
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    // R8: clear register reads as zero
    a_r8_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_sel_i == SEL_CLR) |-> (reg_rdata_o == '0));

    // R8: without set or clear the flags hold
    a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_i == '0) && !(reg_wr_i && reg_sel_i == SEL_CLR))
        |=> (st_q.flags == $past(st_q.flags)));

    // R11: every bit set by hardware is visible after the edge
    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((st_q.flags & $past(set_i)) == $past(set_i)));

    // R9: enable write lands as written
    a_r9_en_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_sel_i == SEL_EN) |=> (st_q.en == $past(reg_wdata_i)));

    // R10: interrupt follows enabled flags one clock later
    a_r10_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.flags & st_q.en) != '0) |=> irq_o);

    a_r10_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.flags & st_q.en) == '0) |=> !irq_o);

endmodule

// File: rtl/agd_access_guard.sv
module agd_access_guard #(
    parameter int NUM_RGN = 4,
    parameter int ADDR_W  = 32,
    parameter int CRC_W   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       acc_valid_i,
    input  logic [ADDR_W-1:0]          acc_addr_i,
    input  logic                       acc_write_i,
    input  logic                       acc_fetch_i,
    input  logic                       enc_mode_i,
    input  logic                       sec_err_i,
    input  logic [NUM_RGN-1:0]         rgn_en_i,
    input  logic [NUM_RGN*ADDR_W-1:0]  rgn_start_i,
    input  logic [NUM_RGN*ADDR_W-1:0]  rgn_end_i,
    input  logic [NUM_RGN*2-1:0]       rgn_mode_i,
    input  logic [NUM_RGN*CRC_W-1:0]   rgn_crc_i,
    input  logic [1:0]                 reg_sel_i,
    input  logic                       reg_wr_i,
    input  logic [2:0]                 reg_wdata_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    output logic                       force_zero_o,
    output logic                       irq_o
);
    import agd_pkg::*;

    localparam int IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;

    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [NUM_RGN-1:0] hit_sel;
    logic [1:0]         mode_sel;
    logic [CRC_W-1:0]   crc_sel;
    logic               xo_set;
    logic               key_set;
    flag_vec_t          set_vec;

    agd_region_match #(
        .NUM_RGN (NUM_RGN),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) i_match (
        .addr_i  (acc_addr_i),
        .en_i    (rgn_en_i),
        .start_i (rgn_start_i),
        .end_i   (rgn_end_i),
        .hit_o   (hit),
        .idx_o   (hit_idx),
        .sel_o   (hit_sel)
    );

    assign mode_sel = rgn_mode_i[hit_idx*2 +: 2];
    assign crc_sel  = rgn_crc_i[hit_idx*CRC_W +: CRC_W];

    agd_access_judge #(
        .CRC_W (CRC_W)
    ) i_judge (
        .valid_i      (acc_valid_i),
        .write_i      (acc_write_i),
        .fetch_i      (acc_fetch_i),
        .enc_mode_i   (enc_mode_i),
        .hit_i        (hit),
        .mode_i       (mode_sel),
        .crc_i        (crc_sel),
        .force_zero_o (force_zero_o),
        .xo_set_o     (xo_set),
        .key_set_o    (key_set)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_SEC] = sec_err_i;
        set_vec[FLAG_XO]  = xo_set;
        set_vec[FLAG_KEY] = key_set;
    end

    agd_flag_regs #(
        .DATA_W (DATA_W)
    ) i_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_i       (set_vec),
        .reg_sel_i   (reg_sel_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    // R1: at most one winner, and it agrees with the chosen index
    a_r1_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit_sel) && (hit == (hit_sel != '0)));

    a_r1_lowest_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |-> hit_sel[hit_idx]);

    // R3: fetch under encrypt mode is refused
    a_r3_enc_fetch_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_fetch_i && !acc_write_i && enc_mode_i) |-> force_zero_o);

    // R4: read of a window with a null checksum is refused
    a_r4_key_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !acc_write_i && hit && crc_sel == '0) |-> force_zero_o);

    // R6: writes are never blocked
    a_r6_write_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_write_i) |-> !force_zero_o);

endmodule

// File: tb/test_agd_access_guard.sv
module test_agd_access_guard;

    localparam int N  = 4;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [AW-1:0]     acc_addr = '0;
    logic              acc_write = 1'b0;
    logic              acc_fetch = 1'b0;
    logic              enc_mode = 1'b0;
    logic              sec_err = 1'b0;
    logic [N-1:0]      rgn_en = '0;
    logic [N*AW-1:0]   rgn_start = '0;
    logic [N*AW-1:0]   rgn_end = '0;
    logic [N*2-1:0]    rgn_mode = '0;
    logic [N*CW-1:0]   rgn_crc = '0;
    logic [1:0]        reg_sel = 2'd0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_wdata = '0;
    logic [DW-1:0]     reg_rdata;
    logic              force_zero;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    agd_access_guard #(.NUM_RGN(N), .ADDR_W(AW), .CRC_W(CW), .DATA_W(DW)) i_agd_access_guard (
        .clk_i(clk), .rst_ni(rst_n),
        .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
        .acc_write_i(acc_write), .acc_fetch_i(acc_fetch),
        .enc_mode_i(enc_mode), .sec_err_i(sec_err),
        .rgn_en_i(rgn_en), .rgn_start_i(rgn_start), .rgn_end_i(rgn_end),
        .rgn_mode_i(rgn_mode), .rgn_crc_i(rgn_crc),
        .reg_sel_i(reg_sel), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .force_zero_o(force_zero), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_rgn(input int i, input bit en, input logic [31:0] lo,
                           input logic [31:0] hi, input logic [1:0] md, input logic [7:0] crc);
        rgn_en[i]            = en;
        rgn_start[i*AW +: AW] = lo;
        rgn_end[i*AW +: AW]   = hi;
        rgn_mode[i*2 +: 2]    = md;
        rgn_crc[i*CW +: CW]   = crc;
    endtask

    // One access cycle; force is checked mid-cycle, returns at the next falling edge
    task automatic acc(input logic [31:0] a, input bit wr, input bit fe,
                       input bit exp, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_fetch = fe;
        #5 chk(tag, {31'd0, force_zero}, {31'd0, exp});
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [2:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_sec();
        @(negedge clk); sec_err = 1'b1;
        @(negedge clk); sec_err = 1'b0;
    endtask

    task automatic clear_all();
        wr_reg(2'd1, 3'b111);
    endtask

    task automatic base_cfg();
        set_rgn(0, 1'b1, 32'h1000, 32'h1FFF, 2'b11, 8'h5A);
        set_rgn(1, 1'b1, 32'h1000, 32'h2FFF, 2'b00, 8'h33);
        set_rgn(2, 1'b0, 32'h8000, 32'h8FFF, 2'b11, 8'h00);
        set_rgn(3, 1'b0, 32'h9000, 32'h9FFF, 2'b00, 8'h00);
    endtask

    task automatic t_reset();
        chk_reg(2'd0, 0, "R12 flags after reset");
        chk_reg(2'd2, 0, "R12 enables after reset");
        chk("R12 irq after reset", {31'd0, irq}, 0);
    endtask

    task automatic t_match();
        base_cfg();
        acc(32'h1800, 0, 0, 1, "R1 overlap lowest index wins");
        acc(32'h2800, 0, 0, 0, "R1 second window only");
        acc(32'h1000, 0, 0, 1, "R1 start bound inclusive");
        acc(32'h1FFF, 0, 0, 1, "R1 end bound inclusive");
        acc(32'h3000, 0, 0, 0, "R1 past end no match");
        acc(32'h0FFF, 0, 0, 0, "R1 before start no match");
        acc(32'h8800, 0, 0, 0, "R1 disabled window ignored");
        rgn_en[0] = 1'b0;
        acc(32'h1800, 0, 0, 0, "R1 fallback to next window");
        rgn_en[0] = 1'b1;
        clear_all();
    endtask

    task automatic t_xo();
        acc(32'h1800, 0, 0, 1, "R2 data read of exec-only window");
        chk_reg(2'd0, 3'b010, "R2 exec flag set");
        clear_all();
        acc(32'h1800, 0, 1, 0, "R3 fetch of exec-only window passes");
        chk_reg(2'd0, 0, "R3 fetch sets no flag");
    endtask

    task automatic t_enc_fetch();
        enc_mode = 1'b1;
        acc(32'h5000, 0, 1, 1, "R3 fetch in encrypt mode outside windows");
        chk_reg(2'd0, 3'b010, "R3 encrypt fetch flag");
        clear_all();
        acc(32'h2800, 0, 0, 0, "R3 data read in encrypt mode passes");
        chk_reg(2'd0, 0, "R3 encrypt data read no flag");
        enc_mode = 1'b0;
    endtask

    task automatic t_key();
        rgn_crc[1*CW +: CW] = 8'h00;
        acc(32'h2800, 0, 0, 1, "R4 null checksum read forced");
        chk_reg(2'd0, 3'b100, "R4 key flag set");
        clear_all();
        chk_reg(2'd0, 0, "R5 key flag cleared");
        acc(32'h2800, 0, 0, 1, "R5 still zero after clear");
        acc(32'h2800, 0, 1, 1, "R4 fetch of null key window forced");
        clear_all();
        rgn_crc[1*CW +: CW] = 8'h33;
        acc(32'h2800, 0, 0, 0, "R5 reads pass after key reload");
        chk_reg(2'd0, 0, "R5 no flag after reload");
    endtask

    task automatic t_write();
        rgn_crc[1*CW +: CW] = 8'h00;
        acc(32'h1800, 1, 0, 0, "R6 write to exec-only window");
        acc(32'h2800, 1, 0, 0, "R6 write to null key window");
        chk_reg(2'd0, 0, "R6 writes set no flag");
        rgn_crc[1*CW +: CW] = 8'h33;
    endtask

    task automatic t_sec();
        pulse_sec();
        chk_reg(2'd0, 3'b001, "R7 security pulse sets bit 0");
        clear_all();
    endtask

    task automatic t_w1c();
        pulse_sec();
        acc(32'h1800, 0, 0, 1, "R8 setup exec flag");
        rgn_crc[1*CW +: CW] = 8'h00;
        acc(32'h2800, 0, 0, 1, "R8 setup key flag");
        rgn_crc[1*CW +: CW] = 8'h33;
        chk_reg(2'd0, 3'b111, "R8 all flags sticky");
        wr_reg(2'd0, 3'b000);
        chk_reg(2'd0, 3'b111, "R8 status write ignored");
        chk_reg(2'd1, 0, "R8 clear register reads zero");
        wr_reg(2'd1, 3'b010);
        chk_reg(2'd0, 3'b101, "R8 clear only bit 1");
        wr_reg(2'd1, 3'b101);
        chk_reg(2'd0, 0, "R8 clear remaining bits");
    endtask

    task automatic t_en();
        wr_reg(2'd2, 3'b101);
        chk_reg(2'd2, 3'b101, "R9 enable readback 101");
        wr_reg(2'd2, 3'b010);
        chk_reg(2'd2, 3'b010, "R9 enable readback 010");
    endtask

    task automatic t_irq();
        // enable is 010 here
        pulse_sec();
        @(negedge clk);
        chk("R10 disabled flag gives no irq", {31'd0, irq}, 0);
        clear_all();
        acc(32'h1800, 0, 0, 1, "R10 raise exec flag");
        chk("R10 irq one cycle after flag", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R10 irq high", {31'd0, irq}, 1);
        wr_reg(2'd2, 3'b000);
        chk("R10 irq lags enable drop", {31'd0, irq}, 1);
        @(negedge clk);
        chk("R10 irq low after disable", {31'd0, irq}, 0);
        clear_all();
    endtask

    task automatic t_same();
        pulse_sec();
        @(negedge clk);
        sec_err = 1'b1; reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 3'b001;
        @(negedge clk);
        sec_err = 1'b0; reg_wr = 1'b0;
        chk_reg(2'd0, 3'b001, "R11 set and clear together stays set");
        clear_all();
        chk_reg(2'd0, 0, "R11 plain clear afterwards");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_match();
        t_xo();
        t_enc_fetch();
        t_key();
        t_write();
        t_sec();
        t_w1c();
        t_en();
        t_irq();
        t_same();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule